// File: doc/BRIEF.md
# Ethernet Inter-Frame Gap Enforcer

This block times the idle spacing between Ethernet frames for a MAC, on both the transmit and receive sides. On the transmit side it holds back the next frame until enough idle bit times have passed since the previous frame ended. The transmit gap comes from one of two programmable values. One applies to a frame that directly follows another. The other applies to a frame that starts from an idle line. The duplex mode and whether a frame is already waiting at end-of-frame decide which one is used.

On the receive side the block counts idle bit times while carrier is absent. When carrier returns, it compares that count against a programmable minimum. A frame that arrives too soon after the previous one is marked for dropping, and the mark stays up for the whole frame.

Time is measured only in cycles that carry the per-bit-time tick, so one design serves every line rate. The tick enable is generated elsewhere. Configuration values come from registers outside the block.

Top module: `ifg_enforcer`

## Requirements
- R1: After reset, `tx_permit` is 1 and `rx_drop` is 0.
- R2: In the cycle after a cycle with `tx_eof` high, `tx_permit` is 0.
- R3: In half duplex (`full_duplex`=0) with `tx_req` low during the `tx_eof` cycle, `tx_permit` returns to 1 in the cycle after the cycle carrying the G-th tick following `tx_eof`, where G is `cfg_gap_single`. Ticks are counted from the cycle after `tx_eof`.
- R4: In half duplex with `tx_req` high during the `tx_eof` cycle, the gap G is `cfg_gap_b2b` instead.
- R5: In full duplex, `cfg_gap_b2b` is used whatever the value of `tx_req`.
- R6: A selected gap of 0 behaves as a gap of 1: `tx_permit` returns after the first tick.
- R7: Cycles with `bit_tick` low do not advance either gap count.
- R8: The transmit gap is captured in the `tx_eof` cycle. Changes to the gap inputs during a count do not alter that count.
- R9: `rx_drop` rises in the cycle after `rx_dv` rises if the idle tick count before it is below `cfg_rx_min`. It stays constant while `rx_dv` stays high and is 0 in the cycle after any cycle with `rx_dv` low.
- R10: A receive gap equal to or above `cfg_rx_min` gives `rx_drop`=0. The idle tick count includes the tick in the cycle where `rx_dv` falls.
- R11: The idle tick count saturates at 255 and starts at 255 after reset, so the first frame after reset is never dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One bit time elapses in this cycle |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_req | input | 1 | A transmit frame is waiting |
| tx_eof | input | 1 | One-cycle strobe: the current transmit frame ends |
| rx_dv | input | 1 | Receive carrier / data valid |
| cfg_gap_single | input | 7 | Transmit gap in bit times for a frame that starts from an idle line (default 96) |
| cfg_gap_b2b | input | 7 | Transmit gap in bit times for back-to-back frames (default 96) |
| cfg_rx_min | input | 8 | Minimum receive gap in bit times (default 80) |
| tx_permit | output | 1 | Next transmit frame may start |
| rx_drop | output | 1 | The current receive frame must be dropped |

## Verification
Assertions are checked on every cycle. They cover the following: `tx_permit` falls after end-of-frame, `tx_permit` comes back only after a tick, `rx_drop` is cleared whenever carrier is absent and held steady through a frame, and the idle count stays pinned at its ceiling. The bench scenarios cover the points that need a known stimulus history. These are the exact tick count for each gap selection across duplex mode and pending request, the zero-gap case, immunity to configuration changes during a count, and the drop decision on both sides of the minimum, including saturation and the first frame after reset.

// File: rtl/ifg_pkg.sv
// Package: shared widths and default configuration values for the
// inter-frame gap enforcer. Assumes gaps are counted in bit times.
package ifg_pkg;
    localparam int TX_GAP_W = 7;
    localparam int RX_GAP_W = 8;
    localparam logic [TX_GAP_W-1:0] TX_GAP_DEFAULT = 7'd96;
    localparam logic [RX_GAP_W-1:0] RX_MIN_DEFAULT = 8'd80;
endpackage

// File: rtl/ifg_tx_timer.sv
// Transmit gap timer. A tx_eof strobe captures the selected gap and
// clears the permit. Each following tick advances the count, and the
// permit returns once max(gap,1) ticks have been seen.
// Assumes tx_eof is a single-cycle strobe.
module ifg_tx_timer #(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             tx_eof,
    input  logic [GAP_W-1:0] gap_sel,
    output logic             permit
);
    localparam int CNT_W = GAP_W + 1;

    logic [GAP_W-1:0] gap_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             done_q;

    // Next count value after one more tick.
    always_comb cnt_inc = cnt_q + 1'b1;

    // Capture the gap at end-of-frame, then count ticks until it is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b1;
        end else if (tx_eof) begin
            gap_q  <= gap_sel;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (bit_tick && !done_q) begin
            cnt_q <= cnt_inc;
            if (cnt_inc >= {1'b0, gap_q}) begin
                done_q <= 1'b1;
            end
        end
    end

    assign permit = done_q;

    // R2: end-of-frame always withdraws the permit.
    a_r2_eof_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |=> !permit);

    // R7: the permit is only regained in a cycle that carried a tick.
    a_r7_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!permit && !tx_eof && !bit_tick) |=> !permit);

    // R3: the count never runs past the captured gap.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q |-> (cnt_q <= {1'b0, gap_q}));
endmodule

// File: rtl/ifg_rx_monitor.sv
// Receive gap monitor. It counts idle ticks while carrier is absent,
// restarting at the falling edge and saturating at all-ones. At the
// rising edge it compares the count with the minimum and holds the
// resulting drop flag for the frame.
// Assumes rx_dv is synchronous to clk.
module ifg_rx_monitor #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_tick,
    input  logic             rx_dv,
    input  logic [GAP_W-1:0] min_gap,
    output logic             drop
);
    localparam logic [GAP_W-1:0] CNT_MAX = '1;

    logic             dv_q;
    logic [GAP_W-1:0] cnt_q;
    logic             drop_q;

    // Track carrier, measure the idle gap and decide the drop at the rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dv_q   <= 1'b0;
            cnt_q  <= CNT_MAX;
            drop_q <= 1'b0;
        end else begin
            dv_q <= rx_dv;
            if (!rx_dv) begin
                drop_q <= 1'b0;
                if (dv_q) begin
                    cnt_q <= {{(GAP_W-1){1'b0}}, bit_tick};
                end else if (bit_tick && cnt_q != CNT_MAX) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else if (!dv_q) begin
                drop_q <= (cnt_q < min_gap);
            end
        end
    end

    assign drop = drop_q;

    // R9: no drop flag survives an idle cycle.
    a_r9_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_dv |=> !drop);

    // R9: the flag is constant through the body of a frame.
    a_r9_drop_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dv && dv_q) |=> $stable(drop));

    // R11: a saturated idle count stays saturated during idle.
    a_r11_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !rx_dv && !dv_q) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/ifg_enforcer.sv
// Inter-frame gap enforcer top. It selects the transmit gap from the
// duplex mode and any pending request, then instantiates the transmit
// timer and the receive monitor.
// Assumes all inputs are synchronous to clk.
module ifg_enforcer
    import ifg_pkg::*;
#(
    parameter int TXW = TX_GAP_W,
    parameter int RXW = RX_GAP_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_tick,
    input  logic           full_duplex,
    input  logic           tx_req,
    input  logic           tx_eof,
    input  logic           rx_dv,
    input  logic [TXW-1:0] cfg_gap_single,
    input  logic [TXW-1:0] cfg_gap_b2b,
    input  logic [RXW-1:0] cfg_rx_min,
    output logic           tx_permit,
    output logic           rx_drop
);
    logic [TXW-1:0] gap_sel;

    // Pick the back-to-back gap in full duplex or when a frame is waiting.
    always_comb gap_sel = (full_duplex || tx_req) ? cfg_gap_b2b : cfg_gap_single;

    ifg_tx_timer #(.GAP_W(TXW)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .tx_eof   (tx_eof),
        .gap_sel  (gap_sel),
        .permit   (tx_permit)
    );

    ifg_rx_monitor #(.GAP_W(RXW)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .rx_dv    (rx_dv),
        .min_gap  (cfg_rx_min),
        .drop     (rx_drop)
    );
endmodule

// File: tb/ifg_enforcer_tb.sv
module ifg_enforcer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b1;
    logic       full_duplex = 1'b0;
    logic       tx_req = 1'b0;
    logic       tx_eof = 1'b0;
    logic       rx_dv = 1'b0;
    logic [6:0] cfg_gap_single = 7'd96;
    logic [6:0] cfg_gap_b2b = 7'd96;
    logic [7:0] cfg_rx_min = 8'd80;
    logic       tx_permit;
    logic       rx_drop;

    int n_checks = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ifg_enforcer u_dut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .full_duplex(full_duplex),
        .tx_req(tx_req), .tx_eof(tx_eof), .rx_dv(rx_dv),
        .cfg_gap_single(cfg_gap_single), .cfg_gap_b2b(cfg_gap_b2b),
        .cfg_rx_min(cfg_rx_min), .tx_permit(tx_permit), .rx_drop(rx_drop)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Pulse end-of-frame and return the number of edges until permit returns.
    task automatic tx_gap(input logic req, output int edges);
        @(negedge clk);
        tx_eof = 1'b1;
        tx_req = req;
        @(negedge clk);
        tx_eof = 1'b0;
        tx_req = 1'b0;
        check("R2 permit low after eof", int'(tx_permit), 0);
        edges = 0;
        while (!tx_permit && edges < 400) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic t_reset;
        check("R1 permit after reset", int'(tx_permit), 1);
        check("R1 drop after reset", int'(rx_drop), 0);
    endtask

    task automatic t_tx_modes;
        int e;
        full_duplex = 1'b0; cfg_gap_single = 7'd12; cfg_gap_b2b = 7'd5;
        tx_gap(1'b0, e); check("R3 half duplex single gap", e, 12);
        tx_gap(1'b1, e); check("R4 half duplex b2b gap", e, 5);
        full_duplex = 1'b1;
        tx_gap(1'b0, e); check("R5 full duplex no req", e, 5);
        tx_gap(1'b1, e); check("R5 full duplex req", e, 5);
        full_duplex = 1'b0; cfg_gap_single = 7'd127;
        tx_gap(1'b0, e); check("R3 max gap", e, 127);
    endtask

    task automatic t_tx_zero;
        int e;
        full_duplex = 1'b0; cfg_gap_single = 7'd0;
        tx_gap(1'b0, e); check("R6 zero gap", e, 1);
        cfg_gap_single = 7'd1;
        tx_gap(1'b0, e); check("R6 gap of one", e, 1);
    endtask

    task automatic t_tx_tick_and_cfg;
        int e;
        full_duplex = 1'b0; cfg_gap_single = 7'd8;
        @(negedge clk);
        tx_eof = 1'b1;
        @(negedge clk);
        tx_eof = 1'b0;
        bit_tick = 1'b0;
        cfg_gap_single = 7'd40;
        for (int i = 0; i < 20; i++) @(negedge clk);
        check("R7 no tick holds permit low", int'(tx_permit), 0);
        bit_tick = 1'b1;
        e = 0;
        while (!tx_permit && e < 400) begin
            @(negedge clk);
            e++;
        end
        check("R8 gap captured at eof", e, 8);
        cfg_gap_single = 7'd96;
    endtask

    // Idle for idle_len cycles (ticking), then raise carrier and check the flag.
    task automatic rx_frame(input int idle_len, input int exp_drop, input string tag);
        @(negedge clk);
        rx_dv = 1'b0;
        for (int i = 1; i < idle_len; i++) @(negedge clk);
        @(negedge clk);
        rx_dv = 1'b1;
        @(negedge clk);
        check(tag, int'(rx_drop), exp_drop);
        for (int i = 0; i < 5; i++) @(negedge clk);
        check("R9 drop held in frame", int'(rx_drop), exp_drop);
        rx_dv = 1'b0;
        @(negedge clk);
        check("R9 drop cleared on idle", int'(rx_drop), 0);
        rx_dv = 1'b1;
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    task automatic t_rx_first;
        cfg_rx_min = 8'd255;
        @(negedge clk);
        rx_dv = 1'b1;
        @(negedge clk);
        check("R11 first frame not dropped", int'(rx_drop), 0);
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    task automatic t_rx_gaps;
        cfg_rx_min = 8'd80;
        rx_frame(79, 1, "R9 short gap dropped");
        rx_frame(80, 0, "R10 gap equal to minimum");
        rx_frame(120, 0, "R10 long gap kept");
        cfg_rx_min = 8'd255;
        rx_frame(254, 1, "R11 below ceiling dropped");
        rx_frame(300, 0, "R11 saturated count kept");
    endtask

    task automatic t_rx_tick;
        cfg_rx_min = 8'd10;
        @(negedge clk);
        rx_dv = 1'b0;
        bit_tick = 1'b0;
        for (int i = 0; i < 30; i++) @(negedge clk);
        bit_tick = 1'b1;
        for (int i = 0; i < 5; i++) @(negedge clk);
        rx_dv = 1'b1;
        @(negedge clk);
        check("R7 idle cycles without tick not counted", int'(rx_drop), 1);
        rx_dv = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_rx_first();
                t_tx_modes();
                t_tx_zero();
                t_tx_tick_and_cfg();
                t_rx_gaps();
                t_rx_tick();
            end
            begin
                repeat (150000) @(negedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule